// File: doc/BRIEF.md
# Parallel Device Interface Register Block

This block is the register file and small transfer sequencer that sit between a host and a 16-bit parallel peripheral. The host reaches it over a simple word-addressed register bus. Writes are single-cycle strobes and reads are combinational. Through these registers the host sets three function lines that are latched out to the device, and it sends one-cycle go, init and power-fail pulses. It reads back the device's live attention, status and parity lines after two-stage synchronizers.

A word-by-word transfer engine is included. The host loads a 32-bit word address and a 16-bit range count, then starts the engine with a go command. Each acknowledged transfer moves the address on by two bytes and counts the range down. The engine stops when the count runs out through zero, or when the bus reports an error or a timeout. End-of-range and rising attention are held in sticky flags. Either flag raises a level interrupt while interrupt enable is set.

Top module: `pdi_regs`

## Requirements
- R1: After reset all registers, latches, flags and the address and range are zero, `irq` is low, and the status word (word index 0) reads ready (bit 7) set with bit 0 equal to the STRAP parameter.
- R2: A command write (word index 0) loads command bits 3..1 into the function latches. `dev_fn[2:0]` follows those bits, status bits 3..1 read them back, and `dma_dir` equals the latch taken from command bit 1 (1 = device to memory).
- R3: A command write with bit 2 set drives `dev_acl` high for exactly the one cycle after the write.
- R4: A command write with bit 0 set drives `dev_go` high for one cycle, starts the engine (`dma_req` high, status bit 7 low) and clears the bus-error and timeout status bits.
- R5: Each cycle with `dma_ack` high while active adds 2 to the 32-bit address and subtracts 1 from the range. The range reads at word index 10, the low address at index 11 and the high address at index 15.
- R6: A step taken while the range is 0 ends the transfer. It sets the end-of-range flag (status bit 15), drops `dma_req` and sets ready, and the range wraps to 0xFFFF. A range of N therefore gives N+1 transfers.
- R7: Command bit 8 forces one transfer step while the engine is active. It has no effect on the range or address while the engine is idle.
- R8: `dma_berr` or `dma_tmo` while active stops the engine without a step and without setting end-of-range. It sets status bit 5 (bus error) or bit 4 (timeout).
- R9: Attention, parity and `dev_stat` pass through two synchronizer stages. Status bit 13 shows live attention, and bits 11, 10 and 9 show `dev_stat[2]`, `[1]` and `[0]`. Bit 14 is set only on a rising edge of synchronized attention, and bit 12 latches any synchronized parity error.
- R10: Command bits 15, 14 and 13 clear the end-of-range, attention-edge and parity flags. If a flag is set and cleared in the same cycle, it ends up set.
- R11: Command bit 6 writes interrupt enable. A write to the pulse register (word index 3) with bit 6 set sets interrupt enable, and one with only bit 5 set clears it; bit 6 takes priority and all other bits do nothing. `irq` = enable AND (end-of-range OR attention-edge).
- R12: Command bit 12 is a master clear. It resets every register, latch, flag and the engine, ignores the other bits of that write, and drives `dev_init` high for one cycle.
- R13: The low and high address are written at word indices 9 and 13 and read at 11 and 15. Writes to the read indices and to unused indices change nothing. Index 2 holds the address modifier (bits 7..0) and interrupt vector (bits 15..8), and each byte is written only when its `bus_be` lane is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index (byte offset / 2) |
| bus_be | input | 2 | Byte lanes for word index 2 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| dev_din | input | 16 | Data from device |
| dev_dout | output | 16 | Data to device |
| dev_fn | output | 3 | Function latches |
| dev_go | output | 1 | Go pulse |
| dev_init | output | 1 | Init pulse from master clear |
| dev_acl | output | 1 | Power-fail pulse |
| dev_attn | input | 1 | Attention line |
| dev_stat | input | 3 | Status lines A, B, C |
| dev_perr | input | 1 | Parity error line |
| dma_req | output | 1 | Transfer request (engine active) |
| dma_ack | input | 1 | Transfer acknowledge |
| dma_berr | input | 1 | Bus error |
| dma_tmo | input | 1 | Bus timeout |
| dma_addr | output | 32 | Current word address |
| dma_dir | output | 1 | 1 = device to memory |
| dma_amod | output | 8 | Address modifier |
| irq | output | 1 | Level interrupt |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The assertions check on every cycle that the engine advances by exactly one word per step, that it goes idle after an end-of-range or an abort, and that go clears the error bits. They also check that a set beats a clear on the attention flag, that the attention flag only rises after a synchronized edge, and that the pulse outputs agree with the state they accompany. Only the bench scenarios can show the exact status word values, the wrap through zero that gives N+1 transfers, and the carry from the low into the high address half. The same holds for writes ignored at the read offsets and for attention held high not setting the flag again.

// File: rtl/pdi_pkg.sv
package pdi_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 2 * WORD_W;
    localparam int IDX_W   = 4;
    localparam int FN_W    = 3;
    localparam int STAT_W  = 3;
    localparam int BYTE_W  = 8;

    // register word indices (byte offset / 2)
    localparam logic [IDX_W-1:0] IDX_CSR   = 4'h0;
    localparam logic [IDX_W-1:0] IDX_DATA  = 4'h1;
    localparam logic [IDX_W-1:0] IDX_AMIV  = 4'h2;
    localparam logic [IDX_W-1:0] IDX_PULSE = 4'h3;
    localparam logic [IDX_W-1:0] IDX_ALO_W = 4'h9;
    localparam logic [IDX_W-1:0] IDX_RANGE = 4'hA;
    localparam logic [IDX_W-1:0] IDX_ALO_R = 4'hB;
    localparam logic [IDX_W-1:0] IDX_AHI_W = 4'hD;
    localparam logic [IDX_W-1:0] IDX_AHI_R = 4'hF;

    // command word bit positions
    localparam int C_CLR_EOR = 15;
    localparam int C_CLR_ATT = 14;
    localparam int C_CLR_PAR = 13;
    localparam int C_MCLR    = 12;
    localparam int C_CYCLE   = 8;
    localparam int C_IE      = 6;
    localparam int C_FN_LO   = 1;
    localparam int C_ACL     = 2;
    localparam int C_GO      = 0;

    // pulse register bit positions
    localparam int P_SET = 6;
    localparam int P_CLR = 5;

    typedef struct packed {
        logic              eor;
        logic              att_edge;
        logic              att_live;
        logic              par_err;
        logic [STAT_W-1:0] abc;
        logic              spare;
        logic              ready;
        logic              ie;
        logic              berr;
        logic              terr;
        logic [FN_W-1:0]   fn;
        logic              strap;
    } status_t;

    function automatic logic [ADDR_W-1:0] next_word_addr(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(2);
    endfunction
endpackage

// File: rtl/pdi_sync.sv
module pdi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pdi_flags.sv
module pdi_flags (
    input  logic clk,
    input  logic rst,
    input  logic mclr,
    input  logic att_live,
    input  logic par_live,
    input  logic eor_hit,
    input  logic clr_eor,
    input  logic clr_att,
    input  logic clr_par,
    output logic eor,
    output logic att_edge,
    output logic par_err
);
    logic att_prev;
    logic set_att;

    assign set_att = att_live && !att_prev;

    always_ff @(posedge clk) begin
        if (rst) att_prev <= 1'b0;
        else     att_prev <= att_live;
    end

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            eor      <= 1'b0;
            att_edge <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            eor      <= eor_hit  || (eor      && !clr_eor);
            att_edge <= set_att  || (att_edge && !clr_att);
            par_err  <= par_live || (par_err  && !clr_par);
        end
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (set_att && !mclr) |=> att_edge);

    assert_rise_only_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(att_edge) |-> ($past(att_live) && !$past(att_prev)));
endmodule

// File: rtl/pdi_dma_seq.sv
module pdi_dma_seq #(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mclr,
    input  logic                go,
    input  logic                force_cycle,
    input  logic                ack,
    input  logic                bus_err,
    input  logic                bus_tmo,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                wr_cnt,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] addr,
    output logic [WORD_W-1:0]   cnt,
    output logic                active,
    output logic                berr_q,
    output logic                terr_q,
    output logic                eor_hit
);
    import pdi_pkg::*;
    localparam int AW = 2 * WORD_W;

    logic step, abort, step_ok;

    assign step    = active && (ack || force_cycle);
    assign abort   = active && (bus_err || bus_tmo);
    assign step_ok = step && !abort;
    assign eor_hit = step_ok && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            addr   <= '0;
            cnt    <= '0;
            active <= 1'b0;
            berr_q <= 1'b0;
            terr_q <= 1'b0;
        end else begin
            if (abort) begin
                active <= 1'b0;
                berr_q <= berr_q || bus_err;
                terr_q <= terr_q || bus_tmo;
            end else if (step) begin
                addr <= next_word_addr(addr);
                cnt  <= cnt - WORD_W'(1);
                if (cnt == '0) active <= 1'b0;
            end
            if (wr_lo)  addr[WORD_W-1:0]  <= wdata;
            if (wr_hi)  addr[AW-1:WORD_W] <= wdata;
            if (wr_cnt) cnt <= wdata;
            if (go) begin
                active <= 1'b1;
                berr_q <= 1'b0;
                terr_q <= 1'b0;
            end
        end
    end

    assert_step_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (step_ok && !mclr && !wr_lo && !wr_hi) |=> (addr == $past(addr) + AW'(2)));

    assert_eor_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (eor_hit && !go && !mclr) |=> !active);

    assert_abort_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (abort && !go && !mclr) |=> (!active && (berr_q || terr_q)));

    assert_go_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (go && !mclr) |=> (active && !berr_q && !terr_q));
endmodule

// File: rtl/pdi_regs.sv
module pdi_regs
    import pdi_pkg::*;
#(
    parameter bit STRAP       = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] dev_din,
    output logic [WORD_W-1:0] dev_dout,
    output logic [FN_W-1:0]   dev_fn,
    output logic              dev_go,
    output logic              dev_init,
    output logic              dev_acl,
    input  logic              dev_attn,
    input  logic [STAT_W-1:0] dev_stat,
    input  logic              dev_perr,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic              dma_berr,
    input  logic              dma_tmo,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_dir,
    output logic [BYTE_W-1:0] dma_amod,
    output logic              irq,
    output logic [BYTE_W-1:0] irq_vec
);
    localparam int SYNC_W = STAT_W + 2;

    logic wr_cmd, wr_pulse, wr_data, wr_amiv;
    logic mclr, go;
    logic [SYNC_W-1:0] sync_q;
    logic att_s, par_s;
    logic [STAT_W-1:0] abc_s;
    logic ie_q;
    logic [WORD_W-1:0] din_q;
    logic [WORD_W-1:0] cnt;
    logic active, berr_q, terr_q, eor_hit;
    logic eor, att_edge, par_err;
    status_t st;

    assign wr_cmd   = bus_wr && (bus_addr == IDX_CSR);
    assign wr_pulse = bus_wr && (bus_addr == IDX_PULSE);
    assign wr_data  = bus_wr && (bus_addr == IDX_DATA);
    assign wr_amiv  = bus_wr && (bus_addr == IDX_AMIV);
    assign mclr     = wr_cmd && bus_wdata[C_MCLR];
    assign go       = wr_cmd && bus_wdata[C_GO] && !mclr;

    pdi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dev_attn, dev_perr, dev_stat}),
        .q   (sync_q)
    );
    assign {att_s, par_s, abc_s} = sync_q;

    pdi_dma_seq #(.WORD_W(WORD_W)) u_dma (
        .clk         (clk),
        .rst         (rst),
        .mclr        (mclr),
        .go          (go),
        .force_cycle (wr_cmd && bus_wdata[C_CYCLE] && !mclr),
        .ack         (dma_ack),
        .bus_err     (dma_berr),
        .bus_tmo     (dma_tmo),
        .wr_lo       (bus_wr && (bus_addr == IDX_ALO_W)),
        .wr_hi       (bus_wr && (bus_addr == IDX_AHI_W)),
        .wr_cnt      (bus_wr && (bus_addr == IDX_RANGE)),
        .wdata       (bus_wdata),
        .addr        (dma_addr),
        .cnt         (cnt),
        .active      (active),
        .berr_q      (berr_q),
        .terr_q      (terr_q),
        .eor_hit     (eor_hit)
    );

    pdi_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .mclr     (mclr),
        .att_live (att_s),
        .par_live (par_s),
        .eor_hit  (eor_hit),
        .clr_eor  (wr_cmd && bus_wdata[C_CLR_EOR]),
        .clr_att  (wr_cmd && bus_wdata[C_CLR_ATT]),
        .clr_par  (wr_cmd && bus_wdata[C_CLR_PAR]),
        .eor      (eor),
        .att_edge (att_edge),
        .par_err  (par_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_go   <= 1'b0;
            dev_init <= 1'b0;
            dev_acl  <= 1'b0;
            din_q    <= '0;
            dev_fn   <= '0;
            ie_q     <= 1'b0;
            dev_dout <= '0;
            dma_amod <= '0;
            irq_vec  <= '0;
        end else begin
            dev_go   <= go;
            dev_init <= mclr;
            dev_acl  <= wr_cmd && bus_wdata[C_ACL] && !mclr;
            din_q    <= dev_din;
            if (mclr) begin
                dev_fn   <= '0;
                ie_q     <= 1'b0;
                dev_dout <= '0;
                dma_amod <= '0;
                irq_vec  <= '0;
            end else begin
                if (wr_cmd) begin
                    dev_fn <= bus_wdata[C_FN_LO +: FN_W];
                    ie_q   <= bus_wdata[C_IE];
                end
                if (wr_pulse) begin
                    if (bus_wdata[P_SET])      ie_q <= 1'b1;
                    else if (bus_wdata[P_CLR]) ie_q <= 1'b0;
                end
                if (wr_data) dev_dout <= bus_wdata;
                if (wr_amiv && bus_be[0]) dma_amod <= bus_wdata[BYTE_W-1:0];
                if (wr_amiv && bus_be[1]) irq_vec  <= bus_wdata[WORD_W-1:BYTE_W];
            end
        end
    end

    always_comb begin
        st          = '0;
        st.eor      = eor;
        st.att_edge = att_edge;
        st.att_live = att_s;
        st.par_err  = par_err;
        st.abc      = abc_s;
        st.ready    = !active;
        st.ie       = ie_q;
        st.berr     = berr_q;
        st.terr     = terr_q;
        st.fn       = dev_fn;
        st.strap    = STRAP;
    end

    always_comb begin
        case (bus_addr)
            IDX_CSR:   bus_rdata = st;
            IDX_DATA:  bus_rdata = din_q;
            IDX_AMIV:  bus_rdata = {irq_vec, dma_amod};
            IDX_RANGE: bus_rdata = cnt;
            IDX_ALO_R: bus_rdata = dma_addr[WORD_W-1:0];
            IDX_AHI_R: bus_rdata = dma_addr[ADDR_W-1:WORD_W];
            default:   bus_rdata = '0;
        endcase
    end

    assign dma_req = active;
    assign dma_dir = dev_fn[0];
    assign irq     = ie_q && (eor || att_edge);

    assert_init_idle_R12: assert property (@(posedge clk) disable iff (rst)
        dev_init |-> !dma_req);

    assert_pulse_sets_ie_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && bus_wdata[P_SET]) |=> ie_q);

    assert_acl_with_fn_R3: assert property (@(posedge clk) disable iff (rst)
        dev_acl |-> dev_fn[1]);
endmodule

// File: tb/pdi_regs_test.sv
module pdi_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] dev_din = 16'h0000;
    logic [15:0] dev_dout;
    logic [2:0]  dev_fn;
    logic        dev_go, dev_init, dev_acl;
    logic        dev_attn = 1'b0;
    logic [2:0]  dev_stat = 3'b000;
    logic        dev_perr = 1'b0;
    logic        dma_req;
    logic        dma_ack = 1'b0, dma_berr = 1'b0, dma_tmo = 1'b0;
    logic [31:0] dma_addr;
    logic        dma_dir;
    logic [7:0]  dma_amod;
    logic        irq;
    logic [7:0]  irq_vec;

    int vectors = 0;
    int fails   = 0;
    bit started = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pdi_regs uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_din(dev_din), .dev_dout(dev_dout),
        .dev_fn(dev_fn), .dev_go(dev_go), .dev_init(dev_init), .dev_acl(dev_acl),
        .dev_attn(dev_attn), .dev_stat(dev_stat), .dev_perr(dev_perr), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_berr(dma_berr), .dma_tmo(dma_tmo), .dma_addr(dma_addr),
        .dma_dir(dma_dir), .dma_amod(dma_amod), .irq(irq), .irq_vec(irq_vec)
    );

    // ---------------- behavioural reference model ----------------
    bit [2:0]  m_fn;
    bit        m_ie, m_go, m_init, m_acl, m_act, m_berr, m_terr, m_eor, m_att, m_par;
    bit [7:0]  m_amod, m_ivec;
    bit [15:0] m_dout, m_din, m_rng;
    bit [31:0] m_addr;
    bit        att_pipe [$];
    bit        par_pipe [$];
    bit [2:0]  abc_pipe [$];
    bit        att_prev;
    bit        wc, mc, set_att, set_par, stp, abt;
    bit [15:0] w;

    function automatic bit [15:0] m_rd(input logic [3:0] i);
        case (i)
            4'h0: return {m_eor, m_att, att_pipe[1], m_par, abc_pipe[1], 1'b0, !m_act,
                          m_ie, m_berr, m_terr, m_fn, 1'b1};
            4'h1: return m_din;
            4'h2: return {m_ivec, m_amod};
            4'hA: return m_rng;
            4'hB: return m_addr[15:0];
            4'hF: return m_addr[31:16];
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        att_pipe = '{0, 0};
        par_pipe = '{0, 0};
        abc_pipe = '{3'b000, 3'b000};
    end

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_fn = 0; m_ie = 0; m_go = 0; m_init = 0; m_acl = 0; m_act = 0;
            m_berr = 0; m_terr = 0; m_eor = 0; m_att = 0; m_par = 0;
            m_amod = 0; m_ivec = 0; m_dout = 0; m_din = 0; m_rng = 0; m_addr = 0;
            att_pipe = '{0, 0}; par_pipe = '{0, 0}; abc_pipe = '{3'b000, 3'b000};
            att_prev = 0;
        end else begin
            w       = bus_wdata;
            wc      = bus_wr && bus_addr == 4'h0;
            mc      = wc && w[12];
            set_att = att_pipe[1] && !att_prev;
            set_par = par_pipe[1];
            stp     = m_act && (dma_ack || (wc && w[8] && !mc));
            abt     = m_act && (dma_berr || dma_tmo);
            att_prev = att_pipe[1];
            att_pipe.push_front(dev_attn);  void'(att_pipe.pop_back());
            par_pipe.push_front(dev_perr);  void'(par_pipe.pop_back());
            abc_pipe.push_front(dev_stat);  void'(abc_pipe.pop_back());
            m_din  = dev_din;
            m_go   = wc && w[0] && !mc;
            m_acl  = wc && w[2] && !mc;
            m_init = mc;
            if (mc) begin
                m_fn = 0; m_ie = 0; m_act = 0; m_berr = 0; m_terr = 0;
                m_eor = 0; m_att = 0; m_par = 0;
                m_amod = 0; m_ivec = 0; m_dout = 0; m_rng = 0; m_addr = 0;
            end else begin
                if (wc && w[15]) m_eor = 0;
                if (wc && w[14]) m_att = 0;
                if (wc && w[13]) m_par = 0;
                if (abt) begin
                    m_act = 0;
                    if (dma_berr) m_berr = 1;
                    if (dma_tmo)  m_terr = 1;
                end else if (stp) begin
                    if (m_rng == 0) begin m_eor = 1; m_act = 0; end
                    m_addr = m_addr + 2;
                    m_rng  = m_rng - 1;
                end
                if (set_att) m_att = 1;
                if (set_par) m_par = 1;
                if (wc) begin m_fn = w[3:1]; m_ie = w[6]; end
                if (bus_wr && bus_addr == 4'h3) begin
                    if (w[6]) m_ie = 1; else if (w[5]) m_ie = 0;
                end
                if (bus_wr && bus_addr == 4'h1) m_dout = w;
                if (bus_wr && bus_addr == 4'h2 && bus_be[0]) m_amod = w[7:0];
                if (bus_wr && bus_addr == 4'h2 && bus_be[1]) m_ivec = w[15:8];
                if (bus_wr && bus_addr == 4'h9) m_addr[15:0]  = w;
                if (bus_wr && bus_addr == 4'hD) m_addr[31:16] = w;
                if (bus_wr && bus_addr == 4'hA) m_rng = w;
                if (m_go) begin m_act = 1; m_berr = 0; m_terr = 0; end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 dev_fn",    dev_fn,   m_fn);
            chk("R2 dma_dir",   dma_dir,  m_fn[0]);
            chk("R3 dev_acl",   dev_acl,  m_acl);
            chk("R4 dev_go",    dev_go,   m_go);
            chk("R5 dma_addr",  dma_addr, m_addr);
            chk("R6 dma_req",   dma_req,  m_act);
            chk("R11 irq",      irq,      m_ie && (m_eor || m_att));
            chk("R12 dev_init", dev_init, m_init);
            chk("R13 dev_dout", dev_dout, m_dout);
            chk("R13 dma_amod", dma_amod, m_amod);
            chk("R13 irq_vec",  irq_vec,  m_ivec);
            chk("R13 rdata",    bus_rdata, m_rd(bus_addr));
        end
    end

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [15:0] d, input logic [1:0] be = 2'b11);
        bus_addr = i; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        steps(1);
        bus_wr = 1'b0; bus_be = 2'b11;
    endtask

    task automatic rd(input string tag, input logic [3:0] i, input logic [15:0] exp);
        bus_addr = i;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        steps(3);
        rst = 1'b0;
        steps(1);
        // R1 reset state
        rd("R1 status after reset", 4'h0, 16'h0081);
        rd("R1 range after reset", 4'hA, 16'h0000);
        chk("R1 irq after reset", irq, 1'b0);

        // R2 function latches
        wr(4'h0, 16'h000A);
        chk("R2 fn out", dev_fn, 3'b101);
        chk("R2 dir", dma_dir, 1'b1);
        chk("R3 no acl without bit2", dev_acl, 1'b0);
        rd("R2 fn readback", 4'h0, 16'h008B);

        // R3 power-fail pulse
        wr(4'h0, 16'h0004);
        chk("R3 acl high", dev_acl, 1'b1);
        steps(1);
        chk("R3 acl one cycle", dev_acl, 1'b0);

        // R13 address / range offsets, ignored writes, byte lanes
        wr(4'h9, 16'hFFFC);
        wr(4'hD, 16'h0001);
        wr(4'hA, 16'h0002);
        wr(4'hB, 16'h1234);
        wr(4'hF, 16'h5555);
        wr(4'h4, 16'hFFFF);
        rd("R13 addr lo read", 4'hB, 16'hFFFC);
        rd("R13 addr hi read", 4'hF, 16'h0001);
        rd("R13 range read", 4'hA, 16'h0002);
        chk("R13 dma_addr", dma_addr, 32'h0001_FFFC);
        wr(4'h2, 16'hBEEF, 2'b10);
        rd("R13 byte lane", 4'h2, 16'hBE00);

        // R4 go
        wr(4'h0, 16'h0001);
        chk("R4 go pulse", dev_go, 1'b1);
        chk("R4 req", dma_req, 1'b1);
        rd("R4 not ready", 4'h0, 16'h0001);
        steps(1);
        chk("R4 go one cycle", dev_go, 1'b0);

        // R5 stepping with carry, R6 end through zero
        dma_ack = 1'b1; steps(1); dma_ack = 1'b0;
        chk("R5 addr +2", dma_addr, 32'h0001_FFFE);
        rd("R5 range -1", 4'hA, 16'h0001);
        dma_ack = 1'b1; steps(1); dma_ack = 1'b0;
        chk("R5 addr carry", dma_addr, 32'h0002_0000);
        chk("R6 still active at 0", dma_req, 1'b1);
        dma_ack = 1'b1; steps(1); dma_ack = 1'b0;
        chk("R6 req drops", dma_req, 1'b0);
        rd("R6 eor and ready", 4'h0, 16'h8081);
        rd("R6 range wraps", 4'hA, 16'hFFFF);
        chk("R6 final addr", dma_addr, 32'h0002_0002);

        // R11 interrupt enable via pulse register
        chk("R11 masked", irq, 1'b0);
        wr(4'h3, 16'h0040);
        chk("R11 pulse set", irq, 1'b1);
        wr(4'h3, 16'h0020);
        chk("R11 pulse clear", irq, 1'b0);
        wr(4'h3, 16'h0060);
        chk("R11 set wins", irq, 1'b1);
        wr(4'h3, 16'h001F);
        chk("R11 other bits ignored", irq, 1'b1);
        wr(4'h0, 16'h8040);
        chk("R10 eor cleared", irq, 1'b0);
        rd("R10 status after clear", 4'h0, 16'h00C1);

        // R7 forced cycle
        wr(4'h0, 16'h0140);
        rd("R7 idle force ignored", 4'hA, 16'hFFFF);
        wr(4'hA, 16'h0003);
        wr(4'h0, 16'h0041);
        wr(4'h0, 16'h0140);
        rd("R7 forced step", 4'hA, 16'h0002);
        chk("R7 forced addr", dma_addr, 32'h0002_0004);
        chk("R7 still active", dma_req, 1'b1);

        // R8 abort
        dma_berr = 1'b1; steps(1); dma_berr = 1'b0;
        chk("R8 berr stops", dma_req, 1'b0);
        rd("R8 berr status", 4'h0, 16'h00E1);
        chk("R8 no irq", irq, 1'b0);
        wr(4'h0, 16'h0041);
        rd("R4 go clears berr", 4'h0, 16'h0041);
        dma_tmo = 1'b1; dma_ack = 1'b1; steps(1); dma_tmo = 1'b0; dma_ack = 1'b0;
        rd("R8 tmo status", 4'h0, 16'h00D1);
        rd("R8 no step on abort", 4'hA, 16'h0002);

        // R9 synchronized inputs, attention edge, parity
        dev_stat = 3'b101; dev_attn = 1'b1;
        steps(2);
        rd("R9 live after two stages", 4'h0, 16'h2AD1);
        steps(1);
        rd("R9 attention edge", 4'h0, 16'h6AD1);
        chk("R11 irq on attention", irq, 1'b1);
        wr(4'h0, 16'h4040);
        steps(3);
        rd("R9 held high no re-set", 4'h0, 16'h2AD1);
        dev_perr = 1'b1; steps(1); dev_perr = 1'b0;
        steps(3);
        rd("R9 parity sticky", 4'h0, 16'h3AD1);
        wr(4'h0, 16'h2040);
        rd("R10 parity cleared", 4'h0, 16'h2AD1);

        // R10 set beats clear
        dev_attn = 1'b0; steps(3);
        dev_attn = 1'b1; steps(2);
        wr(4'h0, 16'h4040);
        rd("R10 set wins", 4'h0, 16'h6AD1);

        // R12 master clear
        wr(4'h0, 16'h0041);
        chk("R12 active before clear", dma_req, 1'b1);
        wr(4'h0, 16'h1000);
        chk("R12 init pulse", dev_init, 1'b1);
        chk("R12 req cleared", dma_req, 1'b0);
        chk("R12 irq cleared", irq, 1'b0);
        chk("R12 addr cleared", dma_addr, 32'h0000_0000);
        rd("R12 status", 4'h0, 16'h2A81);
        rd("R12 vector cleared", 4'h2, 16'h0000);
        steps(1);
        chk("R12 init one cycle", dev_init, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule